// File: doc/BRIEF.md
# Programmable Start-of-Frame Delimiter Detector with Timestamp Capture

This block sits after a demodulator that delivers 4-bit symbols with a valid strobe. It scans for a start-of-frame delimiter, a one-octet value set through a configuration input. The delimiter must come after a run of all-zero preamble symbols. The delimiter travels as two symbols, low nibble first. Once the high-nibble symbol completes a match, the block raises a sync flag and packs each later pair of symbols into a payload byte. The delimiter octet never reaches the byte output. It only fixes the byte boundary.

When the timestamp enable is set, the value of a free-running 32-bit symbol counter is copied into a capture register in the same cycle as the match. The sync flag stays high until an end-of-frame pulse arrives. The end-of-frame pulse also clears the search history and any half-built byte.

The delimiter value can be changed to any octet, including values whose low nibble is zero. Such a zero nibble looks the same as a preamble symbol. The match therefore checks the order of the symbols: it counts the zeros that come before the candidate low-nibble symbol, and it does not count zeros that simply end next to the high-nibble symbol.

Top module: `sfd_sync_detect`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `sync` is 0, `byte_valid` is 0 and `ts_capture` is 0.
- R2: `sync` rises one clock after the valid symbol that equals the high nibble `delim_cfg[7:4]`, and only if the valid symbol just before it equals the low nibble `delim_cfg[3:0]` and the PRE_MIN valid symbols before that one are all zero. With PRE_MIN = 2, a preamble that has only one zero does not synchronize.
- R3: A delimiter whose low or high nibble differs from `delim_cfg` does not set `sync`.
- R4: When `delim_cfg[3:0]` is zero, the zero low-nibble symbol is not counted as preamble. For 0xA0, the symbols 0,0,A do not synchronize and the symbols 0,0,0,A do.
- R5: The two delimiter symbols never produce a byte. The first byte is built from the first two valid symbols that arrive after the cycle of the high-nibble symbol.
- R6: While synchronized, each pair of valid symbols produces `byte_data = {second, first}`. `byte_valid` is a one-cycle pulse that appears one clock after the second symbol.
- R7: If `ts_en` is 1 in the cycle of the matching high-nibble symbol, `ts_capture` takes the `sym_count` value of that cycle, one clock later.
- R8: `ts_capture` keeps its value through every cycle that is not a match with `ts_en` set. This includes a match that occurs while `ts_en` is 0.
- R9: A `frame_end` pulse clears `sync` on the next clock. It discards any pending low nibble and any symbol presented in the same cycle. After it, a new preamble is required.
- R10: Cycles with `sym_valid` = 0 do not change the preamble count, the delimiter search or the byte packing, and they never produce a byte.
- R11: Any programmed octet is honored. For example, 0x5C synchronizes on the symbols C then 5 and ignores 0xA7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_valid | input | 1 | Qualifies `sym` this cycle |
| sym | input | 4 | Received symbol |
| delim_cfg | input | 8 | Programmed delimiter octet; the low nibble arrives first |
| ts_en | input | 1 | Enables timestamp capture on a match |
| sym_count | input | CNT_W (32) | Free-running symbol counter |
| frame_end | input | 1 | End-of-frame pulse; drops synchronization |
| sync | output | 1 | Byte synchronization flag |
| byte_valid | output | 1 | One-cycle payload byte strobe |
| byte_data | output | 8 | Payload byte |
| ts_capture | output | CNT_W (32) | Counter value captured at the last enabled match |

## Verification
The bench builds the detector with the default preamble minimum of two zero symbols and a 32-bit counter. With these values, the short-preamble rejection and the zero-low-nibble ambiguity of R4 each take only three or four symbols to trigger. Because the counter is full width and advances every cycle, a single wrong bit in the capture path gives a mismatch. A behavioural queue model predicts `sync`, the byte strobe, the byte value and the capture register on every clock. Idle gaps and `frame_end` pulses fall inside the preamble and inside the payload.

// File: rtl/sfd_pkg.sv
package sfd_pkg;
    localparam int unsigned SYM_W = 4;
    localparam int unsigned OCT_W = 2 * SYM_W;

    typedef logic [SYM_W-1:0] sym_t;
    typedef logic [OCT_W-1:0] oct_t;

    typedef struct packed {
        logic half;
        sym_t lo;
        logic bv;
        oct_t data;
    } pack_st_t;
endpackage

// File: rtl/sfd_hunt.sv
module sfd_hunt
    import sfd_pkg::*;
#(
    parameter int unsigned PRE_MIN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic sym_valid,
    input  sym_t sym,
    input  oct_t delim,
    output logic hit
);
    localparam int unsigned RUN_W = $clog2(PRE_MIN + 1);

    typedef struct packed {
        logic [RUN_W-1:0] zrun;   // zeros ending at latest symbol
        logic [RUN_W-1:0] zpre;   // zeros ending just before it
        sym_t             prev;   // latest symbol
    } hunt_st_t;

    hunt_st_t q, d;

    always_comb begin
        d   = q;
        hit = sym_valid && !clr
              && (q.prev == delim[SYM_W-1:0])
              && (sym == delim[OCT_W-1:SYM_W])
              && (q.zpre >= RUN_W'(PRE_MIN));
        if (clr || hit) begin
            d = '0;
        end else if (sym_valid) begin
            d.zpre = q.zrun;
            d.prev = sym;
            if (sym != '0) begin
                d.zrun = '0;
            end else if (q.zrun < RUN_W'(PRE_MIN)) begin
                d.zrun = q.zrun + RUN_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/sfd_pack.sv
module sfd_pack
    import sfd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  sym_t sym,
    output logic byte_valid,
    output oct_t byte_data
);
    pack_st_t q, d;

    always_comb begin
        d    = q;
        d.bv = 1'b0;
        if (clr) begin
            d.half = 1'b0;
            d.lo   = '0;
        end else if (en) begin
            if (!q.half) begin
                d.lo   = sym;
                d.half = 1'b1;
            end else begin
                d.data = {sym, q.lo};
                d.bv   = 1'b1;
                d.half = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign byte_valid = q.bv;
    assign byte_data  = q.data;
endmodule

// File: rtl/sfd_sync_detect.sv
module sfd_sync_detect
    import sfd_pkg::*;
#(
    parameter int unsigned PRE_MIN = 2,
    parameter int unsigned CNT_W   = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sym_valid,
    input  logic [3:0]       sym,
    input  logic [7:0]       delim_cfg,
    input  logic             ts_en,
    input  logic [CNT_W-1:0] sym_count,
    input  logic             frame_end,
    output logic             sync,
    output logic             byte_valid,
    output logic [7:0]       byte_data,
    output logic [CNT_W-1:0] ts_capture
);
    typedef struct packed {
        logic             sync;
        logic [CNT_W-1:0] ts;
    } top_st_t;

    top_st_t q, d;
    logic    hunt_hit;

    sfd_hunt #(.PRE_MIN(PRE_MIN)) u_hunt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (frame_end),
        .sym_valid (sym_valid && !q.sync),
        .sym       (sym),
        .delim     (delim_cfg),
        .hit       (hunt_hit)
    );

    sfd_pack u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (frame_end),
        .en         (sym_valid && q.sync),
        .sym        (sym),
        .byte_valid (byte_valid),
        .byte_data  (byte_data)
    );

    always_comb begin
        d = q;
        if (frame_end)     d.sync = 1'b0;
        else if (hunt_hit) d.sync = 1'b1;
        if (hunt_hit && ts_en) d.ts = sym_count;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sync       = q.sync;
    assign ts_capture = q.ts;
endmodule

// File: rtl/sfd_sync_detect_chk.sv
module sfd_sync_detect_chk #(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sym_valid,
    input logic             frame_end,
    input logic             ts_en,
    input logic [CNT_W-1:0] sym_count,
    input logic             hit,
    input logic             sync,
    input logic             byte_valid,
    input logic [CNT_W-1:0] ts_capture
);
    AST_SYNC_RISE_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync) |-> $past(hit)); // R2
    AST_NO_BYTE_UNSYNCED: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> $past(sync)); // R5
    AST_TS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && ts_en) |=> (ts_capture == $past(sym_count))); // R7
    AST_TS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit && ts_en) |=> $stable(ts_capture)); // R8
    AST_FRAME_END_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> (!sync && !byte_valid)); // R9
    AST_IDLE_NO_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_valid |=> !byte_valid); // R10
endmodule

bind sfd_sync_detect sfd_sync_detect_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sym_valid  (sym_valid),
    .frame_end  (frame_end),
    .ts_en      (ts_en),
    .sym_count  (sym_count),
    .hit        (hunt_hit),
    .sync       (sync),
    .byte_valid (byte_valid),
    .ts_capture (ts_capture)
);

// File: tb/tb_sfd_sync_detect.sv
`timescale 1ns/1ps
module tb_sfd_sync_detect;
    localparam int PRE_MIN = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sym_valid = 1'b0;
    logic [3:0]  sym = '0;
    logic [7:0]  delim_cfg = 8'hA7;
    logic        ts_en = 1'b0;
    logic [31:0] sym_count = 32'h1000_0000;
    logic        frame_end = 1'b0;
    logic        sync, byte_valid;
    logic [7:0]  byte_data;
    logic [31:0] ts_capture;

    int checks = 0;
    int failures = 0;

    // reference model state
    int          hist[$];
    int          nib[$];
    bit          m_sync = 0;
    bit          exp_bv = 0;
    logic [7:0]  exp_byte = '0;
    logic [31:0] exp_ts = '0;
    logic [7:0]  got[$];

    always #2 clk = ~clk;

    sfd_sync_detect dut (
        .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym(sym),
        .delim_cfg(delim_cfg), .ts_en(ts_en), .sym_count(sym_count),
        .frame_end(frame_end), .sync(sync), .byte_valid(byte_valid),
        .byte_data(byte_data), .ts_capture(ts_capture)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model(input bit v, input int s, input bit fe);
        exp_bv = 0;
        if (fe) begin
            m_sync = 0;
            hist.delete();
            nib.delete();
        end else if (v) begin
            if (m_sync) begin
                nib.push_back(s);
                if (nib.size() == 2) begin
                    exp_bv = 1;
                    exp_byte = 8'((nib[1] << 4) | nib[0]);
                    nib.delete();
                end
            end else begin
                bit ok;
                hist.push_back(s);
                if (hist.size() > PRE_MIN + 2) void'(hist.pop_front());
                ok = (hist.size() == PRE_MIN + 2)
                     && (hist[PRE_MIN+1] == int'(delim_cfg[7:4]))
                     && (hist[PRE_MIN] == int'(delim_cfg[3:0]));
                for (int i = 0; i < PRE_MIN && ok; i++)
                    if (hist[i] != 0) ok = 0;
                if (ok) begin
                    m_sync = 1;
                    if (ts_en) exp_ts = sym_count;
                    hist.delete();
                end
            end
        end
    endtask

    task automatic step(input bit v, input int s, input bit fe);
        sym_valid = v;
        sym = 4'(s);
        frame_end = fe;
        @(posedge clk);
        model(v, s, fe);
        @(negedge clk);
        chk(sync == m_sync, "R2", "sync", longint'(sync), longint'(m_sync));
        chk(byte_valid == exp_bv, "R6", "byte_valid", longint'(byte_valid), longint'(exp_bv));
        if (exp_bv)
            chk(byte_data == exp_byte, "R6", "byte_data", longint'(byte_data), longint'(exp_byte));
        chk(ts_capture == exp_ts, "R7", "ts_capture", longint'(ts_capture), longint'(exp_ts));
        if (byte_valid) got.push_back(byte_data);
        sym_count = sym_count + 32'd1;
        sym_valid = 1'b0;
        frame_end = 1'b0;
    endtask

    task automatic send(input int s);
        step(1'b1, s, 1'b0);
    endtask

    task automatic zeros(input int n);
        for (int i = 0; i < n; i++) send(0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 0, 1'b0);
    endtask

    task automatic end_frame();
        step(1'b0, 0, 1'b1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] ts_at;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(sync == 1'b0 && byte_valid == 1'b0, "R1", "flags in reset",
            longint'({sync, byte_valid}), 0);
        chk(ts_capture == '0, "R1", "ts in reset", longint'(ts_capture), 0);
        rst_n = 1'b1;
        idle(1);
        chk(sync == 1'b0 && ts_capture == '0, "R1", "after reset",
            longint'(ts_capture), 0);

        // R2 R5 R6 R7: normal frame, delimiter 0xA7
        ts_en = 1'b1;
        got.delete();
        zeros(4);
        send(7);
        ts_at = sym_count;
        send(4'hA);
        chk(sync == 1'b1, "R2", "sync after delimiter", longint'(sync), 1);
        chk(ts_capture == ts_at, "R7", "captured count", longint'(ts_capture), longint'(ts_at));
        send(3); send(5); send(4'hC); send(1);
        chk(got.size() == 2, "R5", "byte count", longint'(got.size()), 2);
        if (got.size() == 2) begin
            chk(got[0] == 8'h53, "R5", "first byte", longint'(got[0]), 8'h53);
            chk(got[1] == 8'h1C, "R6", "second byte", longint'(got[1]), 8'h1C);
        end

        // R9: frame end drops pending nibble and same-cycle symbol
        got.delete();
        send(9);
        step(1'b1, 4, 1'b1);
        chk(sync == 1'b0, "R9", "sync after frame end", longint'(sync), 0);
        send(6); send(2); send(7); send(4'hA);
        chk(sync == 1'b0 && got.size() == 0, "R9", "no sync without preamble",
            longint'(sync), 0);
        end_frame();

        // R2: one-zero preamble is too short
        zeros(1); send(7); send(4'hA);
        chk(sync == 1'b0, "R2", "short preamble", longint'(sync), 0);
        end_frame();

        // R3: wrong high nibble, wrong low nibble, noise before low nibble
        zeros(3); send(7); send(4'hB);
        chk(sync == 1'b0, "R3", "wrong high nibble", longint'(sync), 0);
        zeros(3); send(6); send(4'hA);
        chk(sync == 1'b0, "R3", "wrong low nibble", longint'(sync), 0);
        zeros(2); send(5); send(7); send(4'hA);
        chk(sync == 1'b0, "R3", "noise before delimiter", longint'(sync), 0);
        end_frame();

        // R11 R8: nonstandard value 0x5C, capture disabled
        delim_cfg = 8'h5C;
        ts_en = 1'b0;
        ts_at = ts_capture;
        zeros(3); send(7); send(4'hA);
        chk(sync == 1'b0, "R11", "old value ignored", longint'(sync), 0);
        zeros(2); send(4'hC); send(5);
        chk(sync == 1'b1, "R11", "sync on 0x5C", longint'(sync), 1);
        chk(ts_capture == ts_at, "R8", "ts held when disabled",
            longint'(ts_capture), longint'(ts_at));
        end_frame();

        // R4: zero low nibble, delimiter 0xA0
        delim_cfg = 8'hA0;
        ts_en = 1'b1;
        zeros(2); send(4'hA);
        chk(sync == 1'b0, "R4", "0,0,A rejected", longint'(sync), 0);
        end_frame();
        zeros(3);
        ts_at = sym_count;
        send(4'hA);
        chk(sync == 1'b1, "R4", "0,0,0,A accepted", longint'(sync), 1);
        chk(ts_capture == ts_at, "R7", "capture on 0xA0", longint'(ts_capture), longint'(ts_at));
        end_frame();

        // R10: idle gaps inside preamble, delimiter and payload
        delim_cfg = 8'hA7;
        got.delete();
        ts_at = ts_capture;
        send(0); idle(2); send(0); idle(1); send(7); idle(3); send(4'hA);
        chk(sync == 1'b1, "R10", "gaps keep search", longint'(sync), 1);
        send(8); idle(4);
        chk(got.size() == 0, "R10", "no byte on idle", longint'(got.size()), 0);
        send(2);
        chk(got.size() == 1 && got[0] == 8'h28, "R10", "byte across gap",
            longint'(got.size() > 0 ? got[0] : 8'h00), 8'h28);
        chk(ts_capture != ts_at, "R7", "new capture", longint'(ts_capture), longint'(ts_at));
        ts_at = ts_capture;
        send(1); send(1); idle(2);
        chk(ts_capture == ts_at, "R8", "ts held in payload", longint'(ts_capture), longint'(ts_at));
        end_frame();
        idle(2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule